// File: doc/BRIEF.md
# Delta-Modulated Sample Fetcher

This block plays a one-bit delta-modulated audio stream held in memory. Software programs a start address code, a length code and a control byte, then sets the channel enable. From then on the block reads one byte at a time over a simple request/acknowledge memory port. It requests a byte whenever its single-byte holding buffer is empty and bytes of the sample remain. While each request is outstanding it raises a stall strobe for the processor.

A rate timer picks one of sixteen fixed periods, counted in processor cycles. On every timer expiry the output unit takes one bit of the current byte, least significant bit first. It moves a 7-bit level up or down by two and never steps outside 0..127. When a sample ends, one of two things happens. With looping on, the sample restarts from its start address. Otherwise, if interrupts are enabled, a sticky interrupt flag is set. The flag drives a level interrupt output until a control write clears it or any enable write does.

Top module: `dpcm_fetcher`

## Requirements
- R1: Control byte fields: bit 7 enables the interrupt, bit 6 selects looping, bits 3:0 pick the output period. The periods, in clock cycles, for indices 0 to 15 are 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54.
- R2: On a start or restart the address counter loads 0xC000 + 64*A and the remaining count loads 16*L + 1, where A and L are the last bytes written to the address and length registers.
- R3: When the buffer is empty and bytes remain, `mem_req` rises with `mem_addr` equal to the address counter. Request, address and `cpu_stall` hold until `mem_ack`. The acknowledge stores `mem_rdata` in the buffer, advances the address and decrements the remaining count.
- R4: The address counter advances from 0xFFFF to 0x8000.
- R5: When the last byte is fetched with looping on, the sample restarts with no interrupt, and fetching continues from the start address.
- R6: When the last byte is fetched with looping off and the interrupt enabled, the flag is set. `irq` stays high until the flag is cleared.
- R7: A control write with bit 7 clear clears the flag by the next cycle. If it falls in the same cycle as the final fetch, the clear wins. A control write with bit 7 set leaves the flag as it is.
- R8: Any enable write clears the flag. Writing 0 forces the remaining count to zero, which drops `active` and any pending request. Writing 1 restarts the sample only when the remaining count is zero.
- R9: The output unit works in 8-bit cycles, shifting bits LSB first. A 1 adds 2 and a 0 subtracts 2, with no change if the result would leave 0..127. The level holds while the unit is silent for lack of a buffered byte.
- R10: After reset `level` is 0, and `irq`, `mem_req`, `cpu_stall` and `active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte (interrupt enable, loop, period index) |
| addr_we | input | 1 | Start address code write strobe |
| addr_data | input | 8 | Start address code A |
| len_we | input | 1 | Length code write strobe |
| len_data | input | 8 | Length code L |
| en_we | input | 1 | Channel enable write strobe |
| en_data | input | 1 | Channel enable value |
| mem_req | output | 1 | Byte read request, held until acknowledged |
| mem_addr | output | 16 | Read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 8 | Read data |
| cpu_stall | output | 1 | Processor stall strobe during a fetch |
| irq | output | 1 | Level interrupt from the sticky end-of-sample flag |
| active | output | 1 | Bytes remain in the current sample |
| level | output | 7 | Output level |

## Verification
The end-of-sample flag can be set by the final byte's acknowledge in the same cycle as a register write that is meant to clear it. The bench provokes this by answering the memory by hand and raising the acknowledge on the same edge as the write. Three writes are tried on that edge: a control write with bit 7 clear, a control write with bit 7 set, and a disabling enable write. Afterwards `irq` must be low, high and low respectively, and `active` must be low in every case.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;

    localparam int CTRL_W = 8;
    localparam int RATE_W = 4;
    localparam int PER_W  = 9;

    typedef struct packed {
        logic              irq_en;
        logic              loop;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] v);
        ctrl_t c;
        c.irq_en = v[7];
        c.loop   = v[6];
        c.rate   = v[RATE_W-1:0];
        return c;
    endfunction

    function automatic logic [PER_W-1:0] rate_period(input logic [RATE_W-1:0] idx);
        logic [PER_W-1:0] p;
        case (idx)
            4'd0:    p = 9'd428;
            4'd1:    p = 9'd380;
            4'd2:    p = 9'd340;
            4'd3:    p = 9'd320;
            4'd4:    p = 9'd286;
            4'd5:    p = 9'd254;
            4'd6:    p = 9'd226;
            4'd7:    p = 9'd214;
            4'd8:    p = 9'd190;
            4'd9:    p = 9'd160;
            4'd10:   p = 9'd142;
            4'd11:   p = 9'd128;
            4'd12:   p = 9'd106;
            4'd13:   p = 9'd84;
            4'd14:   p = 9'd72;
            default: p = 9'd54;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dpcm_rate_timer.sv
module dpcm_rate_timer
    import dpcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = (tmr_q.cnt == '0);
        if (tick) begin
            tmr_d.cnt = rate_period(rate) - PER_W'(1);
        end else begin
            tmr_d.cnt = tmr_q.cnt - PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/dpcm_reader.sv
module dpcm_reader
    import dpcm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int REG_W  = 8,
    parameter int A_SH   = 6,
    parameter int L_SH   = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_data,
    input  logic              addr_we,
    input  logic [REG_W-1:0]  addr_data,
    input  logic              len_we,
    input  logic [REG_W-1:0]  len_data,
    input  logic              en_we,
    input  logic              en_data,
    input  logic              mem_ack,
    input  logic [REG_W-1:0]  mem_rdata,
    input  logic              take,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cpu_stall,
    output logic              irq,
    output logic              active,
    output logic              buf_full,
    output logic [REG_W-1:0]  buf_data,
    output logic [RATE_W-1:0] rate
);

    localparam int LEN_W = REG_W + L_SH;
    localparam logic [ADDR_W-1:0] WRAP_ADDR = {1'b1, {(ADDR_W-1){1'b0}}};

    typedef struct packed {
        ctrl_t             ctrl;
        logic [REG_W-1:0]  a_reg;
        logic [REG_W-1:0]  l_reg;
        logic [ADDR_W-1:0] cur;
        logic [LEN_W-1:0]  rem;
        logic              pend;
        logic              bfull;
        logic [REG_W-1:0]  bdata;
        logic              irq;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [ADDR_W-1:0] start_addr;
    logic [LEN_W-1:0]  start_len;

    always_comb begin
        start_addr = BASE_ADDR + (ADDR_W'(rd_q.a_reg) << A_SH);
        start_len  = (LEN_W'(rd_q.l_reg) << L_SH) + LEN_W'(1);

        rd_d = rd_q;
        if (cfg_we)  rd_d.ctrl  = decode_ctrl(cfg_data);
        if (addr_we) rd_d.a_reg = addr_data;
        if (len_we)  rd_d.l_reg = len_data;
        if (take)    rd_d.bfull = 1'b0;

        if (!rd_q.pend && !rd_q.bfull && rd_q.rem != '0) begin
            rd_d.pend = 1'b1;
        end

        if (rd_q.pend && mem_ack) begin
            rd_d.pend  = 1'b0;
            rd_d.bfull = 1'b1;
            rd_d.bdata = mem_rdata;
            rd_d.cur   = (rd_q.cur == '1) ? WRAP_ADDR : rd_q.cur + ADDR_W'(1);
            rd_d.rem   = rd_q.rem - LEN_W'(1);
            if (rd_q.rem == LEN_W'(1)) begin
                if (rd_q.ctrl.loop) begin
                    rd_d.cur = start_addr;
                    rd_d.rem = start_len;
                end else if (rd_q.ctrl.irq_en) begin
                    rd_d.irq = 1'b1;
                end
            end
        end

        if (cfg_we && !cfg_data[7]) rd_d.irq = 1'b0;

        if (en_we) begin
            rd_d.irq = 1'b0;
            if (!en_data) begin
                rd_d.rem  = '0;
                rd_d.pend = 1'b0;
            end else if (rd_q.rem == '0) begin
                rd_d.cur = start_addr;
                rd_d.rem = start_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign mem_req   = rd_q.pend;
    assign mem_addr  = rd_q.cur;
    assign cpu_stall = rd_q.pend;
    assign irq       = rd_q.irq;
    assign active    = (rd_q.rem != '0);
    assign buf_full  = rd_q.bfull;
    assign buf_data  = rd_q.bdata;
    assign rate      = rd_q.ctrl.rate;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !en_we |=> mem_req && $stable(mem_addr));
    // R3
    req_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> active);
    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !cfg_we && !en_we |=> irq);
    // R7
    irq_cfg_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_data[7] |=> !irq);
    // R8
    irq_en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> !irq);
    // R8
    dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we && !en_data |=> !active && !mem_req);

endmodule

// File: rtl/dpcm_output_unit.sv
module dpcm_output_unit #(
    parameter int LVL_W  = 7,
    parameter int BYTE_W = 8,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] buf_data,
    output logic              take,
    output logic [LVL_W-1:0]  level
);

    localparam int LVL_MAX = (1 << LVL_W) - 1;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] shift;
        logic [CNT_W-1:0]  left;
        logic              silent;
        logic [LVL_W-1:0]  level;
    } ou_t;

    ou_t ou_d, ou_q;

    always_comb begin
        ou_d = ou_q;
        take = 1'b0;
        if (tick) begin
            if (!ou_q.silent) begin
                if (ou_q.shift[0]) begin
                    if (ou_q.level <= LVL_W'(LVL_MAX - STEP)) begin
                        ou_d.level = ou_q.level + LVL_W'(STEP);
                    end
                end else if (ou_q.level >= LVL_W'(STEP)) begin
                    ou_d.level = ou_q.level - LVL_W'(STEP);
                end
            end
            ou_d.shift = ou_q.shift >> 1;
            if (ou_q.left == CNT_W'(1)) begin
                ou_d.left = CNT_W'(BYTE_W);
                if (buf_full) begin
                    ou_d.shift  = buf_data;
                    ou_d.silent = 1'b0;
                    take        = 1'b1;
                end else begin
                    ou_d.silent = 1'b1;
                end
            end else begin
                ou_d.left = ou_q.left - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ou_q.shift  <= '0;
            ou_q.left   <= CNT_W'(1);
            ou_q.silent <= 1'b1;
            ou_q.level  <= '0;
        end else begin
            ou_q <= ou_d;
        end
    end

    assign level = ou_q.level;

    // R9
    lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(level) == int'($past(level)))
              || (int'(level) == int'($past(level)) + STEP)
              || (int'(level) + STEP == int'($past(level))));
    // R9
    take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> buf_full);
    // R9
    lvl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level));

endmodule

// File: rtl/dpcm_fetcher.sv
module dpcm_fetcher
    import dpcm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int REG_W  = 8,
    parameter int LVL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_data,
    input  logic              addr_we,
    input  logic [REG_W-1:0]  addr_data,
    input  logic              len_we,
    input  logic [REG_W-1:0]  len_data,
    input  logic              en_we,
    input  logic              en_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [REG_W-1:0]  mem_rdata,
    output logic              cpu_stall,
    output logic              irq,
    output logic              active,
    output logic [LVL_W-1:0]  level
);

    logic              tick;
    logic              take;
    logic              buf_full;
    logic [REG_W-1:0]  buf_data;
    logic [RATE_W-1:0] rate;

    dpcm_reader #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W)
    ) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_data  (cfg_data),
        .addr_we   (addr_we),
        .addr_data (addr_data),
        .len_we    (len_we),
        .len_data  (len_data),
        .en_we     (en_we),
        .en_data   (en_data),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .take      (take),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .cpu_stall (cpu_stall),
        .irq       (irq),
        .active    (active),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .rate      (rate)
    );

    dpcm_rate_timer u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (rate),
        .tick  (tick)
    );

    dpcm_output_unit #(
        .LVL_W  (LVL_W),
        .BYTE_W (REG_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .take     (take),
        .level    (level)
    );

endmodule

// File: tb/dpcm_fetcher_bench.sv
`timescale 1ns/1ps
module dpcm_fetcher_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, addr_we = 1'b0, len_we = 1'b0, en_we = 1'b0;
    logic [7:0]  cfg_data = '0, addr_data = '0, len_data = '0;
    logic        en_data = 1'b0;
    logic        mem_req, cpu_stall, irq, active;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [6:0]  level;

    int          errs = 0, checks = 0, cyc = 0;
    int          fetch_cnt = 0;
    logic [15:0] addr_log [0:127];
    logic        mem_auto = 1'b0;
    logic [7:0]  mem_byte = '0;

    localparam int SEL_CFG = 0, SEL_ADDR = 1, SEL_LEN = 2, SEL_EN = 3;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dpcm_fetcher u_dpcm_fetcher (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_data(cfg_data),
        .addr_we(addr_we), .addr_data(addr_data),
        .len_we(len_we), .len_data(len_data),
        .en_we(en_we), .en_data(en_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cpu_stall(cpu_stall), .irq(irq), .active(active), .level(level)
    );

    // automatic memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_auto) begin
                if (mem_ack) begin
                    mem_ack = 1'b0;
                end else if (mem_req) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem_byte;
                    if (fetch_cnt < 128) addr_log[fetch_cnt] = mem_addr;
                    fetch_cnt = fetch_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        mem_auto = 1'b0; mem_ack = 1'b0;
        cfg_we = 0; addr_we = 0; len_we = 0; en_we = 0;
        rst_n = 1'b0;
        wcyc(3);
        rst_n = 1'b1;
        fetch_cnt = 0;
        wcyc(1);
    endtask

    task automatic wr(input int sel, input logic [7:0] v);
        @(negedge clk);
        case (sel)
            SEL_CFG:  begin cfg_we = 1'b1;  cfg_data = v;  end
            SEL_ADDR: begin addr_we = 1'b1; addr_data = v; end
            SEL_LEN:  begin len_we = 1'b1;  len_data = v;  end
            default:  begin en_we = 1'b1;   en_data = v[0]; end
        endcase
        @(negedge clk);
        cfg_we = 0; addr_we = 0; len_we = 0; en_we = 0;
    endtask

    task automatic play(input logic [7:0] c, input logic [7:0] a,
                        input logic [7:0] l, input logic [7:0] b);
        wr(SEL_CFG, c); wr(SEL_ADDR, a); wr(SEL_LEN, l);
        mem_byte = b; mem_auto = 1'b1;
        wr(SEL_EN, 8'd1);
    endtask

    task automatic wait_change(output int t);
        logic [6:0] p;
        p = level; t = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (level != p) begin t = cyc; break; end
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 level", level, 0);
        chk("R10 irq", irq, 0);
        chk("R10 mem_req", mem_req, 0);
        chk("R10 cpu_stall", cpu_stall, 0);
        chk("R10 active", active, 0);
    endtask

    task automatic t_rate(input logic [3:0] idx, input int per);
        int t1, t2;
        do_reset();
        play({4'h0, idx}, 8'h00, 8'h00, 8'hFF);
        wait_change(t1);
        wait_change(t2);
        chk("R1 period", t2 - t1, per);
    endtask

    task automatic t_lsb_first();
        do_reset();
        play(8'h0F, 8'h03, 8'h00, 8'h0F);
        wcyc(2000);
        chk("R9 lsb first 0x0F", level, 0);
        chk("R2 start addr A=3", addr_log[0], 16'hC0C0);
        chk("R2 length L=0", fetch_cnt, 1);
        do_reset();
        play(8'h0F, 8'h00, 8'h00, 8'hF0);
        wcyc(2000);
        chk("R9 lsb first 0xF0", level, 8);
        wcyc(2000);
        chk("R9 silent hold", level, 8);
    endtask

    task automatic t_clamp();
        do_reset();
        play(8'h0F, 8'h00, 8'h01, 8'hFF);
        wcyc(8400);
        chk("R9 upper clamp", level, 126);
        chk("R2 length L=1", fetch_cnt, 17);
        mem_byte = 8'h00;
        wr(SEL_EN, 8'd1);
        wcyc(8400);
        chk("R9 lower clamp", level, 0);
        chk("R8 restart when zero", fetch_cnt, 34);
    endtask

    task automatic t_wrap();
        do_reset();
        play(8'h0F, 8'hFF, 8'h04, 8'hAA);
        wcyc(29600);
        chk("R2 count 16L+1", fetch_cnt, 65);
        chk("R2 first addr", addr_log[0], 16'hFFC0);
        chk("R4 last before wrap", addr_log[63], 16'hFFFF);
        chk("R4 wrap target", addr_log[64], 16'h8000);
        chk("R6 no irq when disabled", irq, 0);
        chk("R3 active done", active, 0);
    endtask

    task automatic t_loop();
        do_reset();
        play(8'h4F, 8'h01, 8'h00, 8'h55);
        wcyc(3000);
        chk("R5 keeps fetching", (fetch_cnt >= 5) ? 1 : 0, 1);
        chk("R5 restart addr", addr_log[4], 16'hC040);
        chk("R5 no irq", irq, 0);
        chk("R5 still active", active, 1);
        wr(SEL_CFG, 8'h8F);
        wcyc(1000);
        chk("R6 irq after loop off", irq, 1);
        chk("R6 inactive after loop off", active, 0);
    endtask

    task automatic t_irq();
        do_reset();
        play(8'h8F, 8'h00, 8'h00, 8'h00);
        wcyc(100);
        chk("R6 irq set", irq, 1);
        chk("R6 inactive", active, 0);
        wcyc(2000);
        chk("R6 irq held", irq, 1);
        wr(SEL_CFG, 8'h8E);
        chk("R7 bit7 set keeps irq", irq, 1);
        wr(SEL_CFG, 8'h0F);
        chk("R7 bit7 clear clears irq", irq, 0);
        wr(SEL_CFG, 8'h8F);
        wr(SEL_EN, 8'd1);
        chk("R8 enable write clears irq", irq, 0);
        wcyc(100);
        chk("R8 restart refetch", fetch_cnt, 2);
        chk("R6 irq set again", irq, 1);
        wr(SEL_EN, 8'd0);
        chk("R8 disable write clears irq", irq, 0);
    endtask

    task automatic t_disable();
        int c0, c1;
        logic [6:0] lv;
        do_reset();
        play(8'h0F, 8'h00, 8'h01, 8'hFF);
        wcyc(1500);
        c0 = fetch_cnt;
        wr(SEL_EN, 8'd1);
        wcyc(1000);
        chk("R8 enable while playing no restart", addr_log[c0], 16'hC000 + c0);
        wr(SEL_EN, 8'd0);
        chk("R8 disable drops active", active, 0);
        c1 = fetch_cnt;
        wcyc(1000);
        lv = level;
        wcyc(2000);
        chk("R8 no fetch after disable", fetch_cnt, c1);
        chk("R8 silent after drain", level, lv);
        wr(SEL_EN, 8'd1);
        wcyc(50);
        chk("R8 restart from start", addr_log[c1], 16'hC000);
        chk("R8 active after restart", active, 1);
    endtask

    // manual memory: final acknowledge meets a register write on the same edge
    task automatic t_same_cycle(input int sel, input logic [7:0] v, input int exp_irq);
        do_reset();
        wr(SEL_CFG, 8'h8F); wr(SEL_ADDR, 8'h02); wr(SEL_LEN, 8'h00);
        wr(SEL_EN, 8'd1);
        for (int i = 0; i < 100; i++) begin
            if (mem_req) break;
            @(negedge clk);
        end
        chk("R3 req raised", mem_req, 1);
        chk("R3 stall raised", cpu_stall, 1);
        chk("R3 req addr", mem_addr, 16'hC080);
        wcyc(5);
        chk("R3 req held", mem_req, 1);
        chk("R3 stall held", cpu_stall, 1);
        mem_ack = 1'b1; mem_rdata = 8'h33;
        if (sel == SEL_CFG) begin cfg_we = 1'b1; cfg_data = v; end
        else begin en_we = 1'b1; en_data = v[0]; end
        @(negedge clk);
        mem_ack = 1'b0; cfg_we = 1'b0; en_we = 1'b0;
        chk("R7 same-cycle irq", irq, exp_irq);
        chk("R3 req dropped", mem_req, 0);
        chk("R3 stall dropped", cpu_stall, 0);
        chk("R3 done active", active, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_rate(4'd15, 54);
        t_rate(4'd8, 190);
        t_rate(4'd0, 428);
        t_lsb_first();
        t_clamp();
        t_wrap();
        t_loop();
        t_irq();
        t_disable();
        t_same_cycle(SEL_CFG, 8'h0F, 0);
        t_same_cycle(SEL_CFG, 8'h8F, 1);
        t_same_cycle(SEL_EN, 8'h00, 0);
        summary();
        $finish;
    end

endmodule